// File: doc/BRIEF.md
# Two-Level Mapping Table Entry Writer

This block stores one 64-bit mapping entry into an in-memory table on behalf of a command processor. Two tables are supported: a device table, whose entries hold a per-device translation table address and an event-ID width, and a collection table, whose entries hold a target processor number. Each table has its own configuration: a base address, an enable flag, a flag that selects a two-level layout, and the page size and entry size, each given as a base-two logarithm.

A requester presents the request fields and pulses `start`. The block captures the request and the configuration of the chosen table. It then builds the entry word and works out where the entry goes. In a flat table the entry goes straight to its slot. In a two-level table the block first fetches an 8-byte level-1 descriptor, checks the descriptor's valid bit, and writes the entry into the level-2 page that the descriptor points to. All memory traffic uses one request/acknowledge port. The end of the request is signalled by a one-cycle `done` pulse, and `err` is raised alongside `done` if the memory reported an error.

Top module: `tbl_entry_writer`

## Requirements
- R1: If the selected table's enable flag is clear, the request makes no memory access, and `done` rises in the cycle after the clock edge that sampled `start`, with `err` at 0.
- R2: For a flat table, one write is issued to base + (ID << entry_log2).
- R3: For a two-level table, one read is issued first, to base + ((ID >> (page_log2 - 3)) << 3).
- R4: If the level-1 descriptor read returns bit 63 clear, no write follows, and the request completes with `err` at 0.
- R5: If the descriptor is valid, its bits [50:0] are the level-2 base, and one write is issued to that base + ((ID mod 2^(page_log2 - entry_log2)) << entry_log2).
- R6: A collection entry with the map flag set carries 1 in bit 0, the 16-bit processor number in bits [16:1], and zeros in the rest.
- R7: A device entry with the map flag set carries 1 in bit 0, the 5-bit width field in bits [5:1], the 44-bit table address in bits [49:6], and zeros in bits [63:50].
- R8: A request whose map flag is 0 writes an all-zero entry.
- R9: An error on the descriptor read ends the request without a write, with `err` set during the `done` pulse.
- R10: An error on the entry write is reported by `err` being set during the `done` pulse.
- R11: `start` has no effect while `busy` is high. `done` lasts exactly one cycle. While `mem_req` waits for `mem_ack`, the address, direction and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a request (taken only when idle) |
| req_kind | input | 1 | 0 = device table, 1 = collection table |
| req_id | input | 32 | Device or collection ID |
| req_map | input | 1 | 1 = map, 0 = unmap (zero entry) |
| req_size | input | 5 | Event-ID width field for a device entry |
| req_itt | input | 44 | Translation table address for a device entry |
| req_proc | input | 16 | Target processor number for a collection entry |
| dev_base | input | 64 | Device table base address |
| dev_on | input | 1 | Device table enabled |
| dev_two_lvl | input | 1 | Device table is two-level |
| dev_pg_log2 | input | 5 | log2 of the device table page size (at least 3) |
| dev_ent_log2 | input | 4 | log2 of the device entry size (at most page_log2) |
| coll_base | input | 64 | Collection table base address |
| coll_on | input | 1 | Collection table enabled |
| coll_two_lvl | input | 1 | Collection table is two-level |
| coll_pg_log2 | input | 5 | log2 of the collection table page size |
| coll_ent_log2 | input | 4 | log2 of the collection entry size |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_err | input | 1 | Error flag, valid with `mem_ack` |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Memory error, valid with `done` |

## Verification
A wrong captured request or configuration, or a wrong level-2 base, appears at the ports at once as a wrong `mem_addr` or `mem_wdata` on the first memory transaction that uses it. A state machine that takes the wrong branch after the descriptor returns shows up on the next cycle, as an extra or missing write or a wrong `err` on `done`. Requests that arrive while the block is busy and change the inputs would show up as a second write, or as a write to the second request's address.

// File: rtl/tbl_wr_pkg.sv
package tbl_wr_pkg;

    parameter int ADDR_W = 64;
    parameter int ID_W   = 32;
    parameter int DATA_W = 64;
    parameter int PROC_W = 16;
    parameter int SZ_W   = 5;
    parameter int ITT_W  = 44;
    parameter int PGL_W  = 5;
    parameter int ENL_W  = 4;

    localparam int L1_DESC_LOG2 = 3;
    localparam int L1_VALID_BIT = 63;
    localparam int L2_BASE_W    = 51;
    localparam int COLL_USED_W  = PROC_W + 1;
    localparam int DEV_USED_W   = ITT_W + SZ_W + 1;

    typedef enum logic {
        TBL_DEV  = 1'b0,
        TBL_COLL = 1'b1
    } tbl_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              on;
        logic              two_lvl;
        logic [PGL_W-1:0]  pg_log2;
        logic [ENL_W-1:0]  ent_log2;
    } tbl_cfg_t;

    typedef struct packed {
        tbl_kind_e         kind;
        logic [ID_W-1:0]   id;
        logic              map;
        logic [SZ_W-1:0]   size;
        logic [ITT_W-1:0]  itt;
        logic [PROC_W-1:0] proc;
    } tbl_req_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_L1RD = 2'd1,
        ST_WR   = 2'd2,
        ST_DONE = 2'd3
    } tbl_st_e;

    function automatic logic [DATA_W-1:0] coll_word(input logic [PROC_W-1:0] p);
        return DATA_W'({p, 1'b1});
    endfunction

    function automatic logic [DATA_W-1:0] dev_word(input logic [ITT_W-1:0] a,
                                                   input logic [SZ_W-1:0]  s);
        return DATA_W'({a, s, 1'b1});
    endfunction

endpackage

// File: rtl/tbl_entry_pack.sv
module tbl_entry_pack
    import tbl_wr_pkg::*;
(
    input  tbl_req_t          req,
    output logic [DATA_W-1:0] entry
);
    always_comb begin
        if (!req.map) begin
            entry = '0;
        end else if (req.kind == TBL_COLL) begin
            entry = coll_word(req.proc);
        end else begin
            entry = dev_word(req.itt, req.size);
        end
    end
endmodule

// File: rtl/tbl_addr_calc.sv
module tbl_addr_calc
    import tbl_wr_pkg::*;
(
    input  tbl_cfg_t               cfg,
    input  logic [ID_W-1:0]        id,
    input  logic [L2_BASE_W-1:0]   l2base,
    output logic [ADDR_W-1:0]      flat_addr,
    output logic [ADDR_W-1:0]      l1_addr,
    output logic [ADDR_W-1:0]      l2_addr
);
    logic [ADDR_W-1:0] id_ext;
    logic [PGL_W-1:0]  l1_sh;
    logic [PGL_W-1:0]  slot_sh;
    logic [ADDR_W-1:0] slot_mask;
    logic [ADDR_W-1:0] l1_idx;

    always_comb begin
        id_ext    = ADDR_W'(id);
        l1_sh     = cfg.pg_log2 - PGL_W'(L1_DESC_LOG2);
        slot_sh   = cfg.pg_log2 - PGL_W'(cfg.ent_log2);
        slot_mask = (ADDR_W'(1) << slot_sh) - ADDR_W'(1);
        l1_idx    = id_ext >> l1_sh;
        flat_addr = cfg.base + (id_ext << cfg.ent_log2);
        l1_addr   = cfg.base + (l1_idx << L1_DESC_LOG2);
        l2_addr   = ADDR_W'(l2base) + ((id_ext & slot_mask) << cfg.ent_log2);
    end
endmodule

// File: rtl/tbl_seq_ctrl.sv
module tbl_seq_ctrl
    import tbl_wr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  tbl_req_t             req_in,
    input  tbl_cfg_t             cfg_in,
    output tbl_req_t             req_q,
    output tbl_cfg_t             cfg_q,
    output logic [L2_BASE_W-1:0] l2base_q,
    input  logic [ADDR_W-1:0]    flat_addr,
    input  logic [ADDR_W-1:0]    l1_addr,
    input  logic [ADDR_W-1:0]    l2_addr,
    input  logic [DATA_W-1:0]    entry,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic                 mem_ack,
    input  logic                 mem_err,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 busy,
    output logic                 done,
    output logic                 err
);
    tbl_st_e state;
    logic    err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            err_q    <= 1'b0;
            req_q    <= '0;
            cfg_q    <= '0;
            l2base_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        req_q <= req_in;
                        cfg_q <= cfg_in;
                        err_q <= 1'b0;
                        if (!cfg_in.on)
                            state <= ST_DONE;
                        else if (cfg_in.two_lvl)
                            state <= ST_L1RD;
                        else
                            state <= ST_WR;
                    end
                end
                ST_L1RD: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            err_q <= 1'b1;
                            state <= ST_DONE;
                        end else if (!mem_rdata[L1_VALID_BIT]) begin
                            state <= ST_DONE;
                        end else begin
                            l2base_q <= mem_rdata[L2_BASE_W-1:0];
                            state    <= ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (mem_ack) begin
                        err_q <= mem_err;
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = (state == ST_L1RD) || (state == ST_WR);
        mem_we    = (state == ST_WR);
        mem_addr  = (state == ST_L1RD) ? l1_addr :
                    (cfg_q.two_lvl ? l2_addr : flat_addr);
        mem_wdata = entry;
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        err       = done && err_q;
    end

    // R11
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    rd_err_abort_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we && mem_ack && mem_err |=> done && err && !mem_req);

    // R4
    bad_desc_skip_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we && mem_ack && !mem_err && !mem_rdata[L1_VALID_BIT] |=> done && !err && !mem_req);

    // R6
    coll_layout_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && (req_q.kind == TBL_COLL) |-> mem_wdata[DATA_W-1:COLL_USED_W] == '0);

    // R7
    dev_layout_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && (req_q.kind == TBL_DEV) |-> mem_wdata[DATA_W-1:DEV_USED_W] == '0);
endmodule

// File: rtl/tbl_entry_writer.sv
module tbl_entry_writer
    import tbl_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              req_kind,
    input  logic [ID_W-1:0]   req_id,
    input  logic              req_map,
    input  logic [SZ_W-1:0]   req_size,
    input  logic [ITT_W-1:0]  req_itt,
    input  logic [PROC_W-1:0] req_proc,
    input  logic [ADDR_W-1:0] dev_base,
    input  logic              dev_on,
    input  logic              dev_two_lvl,
    input  logic [PGL_W-1:0]  dev_pg_log2,
    input  logic [ENL_W-1:0]  dev_ent_log2,
    input  logic [ADDR_W-1:0] coll_base,
    input  logic              coll_on,
    input  logic              coll_two_lvl,
    input  logic [PGL_W-1:0]  coll_pg_log2,
    input  logic [ENL_W-1:0]  coll_ent_log2,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              err
);
    tbl_req_t             req_in, req_q;
    tbl_cfg_t             cfg_in, cfg_q;
    logic [L2_BASE_W-1:0] l2base_q;
    logic [ADDR_W-1:0]    flat_addr, l1_addr, l2_addr;
    logic [DATA_W-1:0]    entry;

    always_comb begin
        req_in.kind = tbl_kind_e'(req_kind);
        req_in.id   = req_id;
        req_in.map  = req_map;
        req_in.size = req_size;
        req_in.itt  = req_itt;
        req_in.proc = req_proc;
        if (req_kind == TBL_COLL)
            cfg_in = '{base: coll_base, on: coll_on, two_lvl: coll_two_lvl,
                       pg_log2: coll_pg_log2, ent_log2: coll_ent_log2};
        else
            cfg_in = '{base: dev_base, on: dev_on, two_lvl: dev_two_lvl,
                       pg_log2: dev_pg_log2, ent_log2: dev_ent_log2};
    end

    tbl_seq_ctrl u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_in    (req_in),
        .cfg_in    (cfg_in),
        .req_q     (req_q),
        .cfg_q     (cfg_q),
        .l2base_q  (l2base_q),
        .flat_addr (flat_addr),
        .l1_addr   (l1_addr),
        .l2_addr   (l2_addr),
        .entry     (entry),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );

    tbl_addr_calc u_addr (
        .cfg       (cfg_q),
        .id        (req_q.id),
        .l2base    (l2base_q),
        .flat_addr (flat_addr),
        .l1_addr   (l1_addr),
        .l2_addr   (l2_addr)
    );

    tbl_entry_pack u_pack (
        .req   (req_q),
        .entry (entry)
    );
endmodule

// File: tb/tbl_entry_writer_test.sv
`timescale 1ns/1ps
module tbl_entry_writer_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        req_kind;
    logic [31:0] req_id;
    logic        req_map;
    logic [4:0]  req_size;
    logic [43:0] req_itt;
    logic [15:0] req_proc;
    logic [63:0] dev_base, coll_base;
    logic        dev_on, dev_two_lvl, coll_on, coll_two_lvl;
    logic [4:0]  dev_pg_log2, coll_pg_log2;
    logic [3:0]  dev_ent_log2, coll_ent_log2;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [63:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, done, err;

    int total = 0;
    int bad   = 0;
    int n_rd  = 0;
    int n_wr  = 0;
    logic [63:0] last_raddr, last_waddr, last_wdata;
    bit inj_rd = 0;
    bit inj_wr = 0;
    int dly    = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tbl_entry_writer uut (
        .clk(clk), .rst(rst), .start(start), .req_kind(req_kind), .req_id(req_id),
        .req_map(req_map), .req_size(req_size), .req_itt(req_itt), .req_proc(req_proc),
        .dev_base(dev_base), .dev_on(dev_on), .dev_two_lvl(dev_two_lvl),
        .dev_pg_log2(dev_pg_log2), .dev_ent_log2(dev_ent_log2),
        .coll_base(coll_base), .coll_on(coll_on), .coll_two_lvl(coll_two_lvl),
        .coll_pg_log2(coll_pg_log2), .coll_ent_log2(coll_ent_log2),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .err(err)
    );

    function automatic logic [63:0] desc_for(input logic [63:0] a);
        logic       v;
        logic [50:0] b;
        v = (a[5:3] != 3'd0);
        b = {a[38:0], 12'h000};
        return {v, 12'h000, b};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // memory responder, driven at the falling edge
    initial begin
        mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                mem_err = 1'b0;
            end else if (mem_req && !rst) begin
                if (dly != 0) begin
                    dly--;
                end else begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        n_wr++;
                        last_waddr = mem_addr;
                        last_wdata = mem_wdata;
                        mem_err    = inj_wr;
                    end else begin
                        n_rd++;
                        last_raddr = mem_addr;
                        mem_rdata  = desc_for(mem_addr);
                        mem_err    = inj_rd;
                    end
                    dly = int'($urandom % 3);
                end
            end
        end
    end

    task automatic run_txn(input bit kind, input logic [31:0] id, input bit map,
                           input logic [4:0] sz, input logic [43:0] itt, input logic [15:0] pr,
                           input logic [63:0] base, input bit on, input bit two,
                           input logic [4:0] pg, input logic [3:0] ent,
                           input bit erd, input bit ewr, input bit poke);
        int rd0, wr0, cyc;
        bit poked;
        logic [63:0] id64, l1, desc, l2b, waddr, wdata;
        bit exp_rd, exp_wr, exp_err;
        string wtag, etag;

        id64 = {32'h0, id};
        l1 = base + ((id64 >> (pg - 5'd3)) * 64'd8);
        desc = desc_for(l1);
        l2b = {13'h0, desc[50:0]};
        exp_rd = on && two;
        exp_wr = on && (!two || (!erd && desc[63]));
        exp_err = on && ((two && erd) || (exp_wr && ewr));
        waddr = two ? l2b + ((id64 % (64'd1 << (pg - {1'b0, ent}))) * (64'd1 << ent))
                    : base + id64 * (64'd1 << ent);
        if (!map) wdata = '0;
        else if (kind) wdata = {47'h0, pr, 1'b1};
        else wdata = {14'h0, itt, sz, 1'b1};
        wtag = two ? "R5" : "R2";
        etag = !on ? "R1" : (two && erd) ? "R9" : ewr ? "R10" : (two && !desc[63]) ? "R4" : "R2";

        req_kind = kind; req_id = id; req_map = map; req_size = sz; req_itt = itt; req_proc = pr;
        if (kind) begin
            coll_base = base; coll_on = on; coll_two_lvl = two; coll_pg_log2 = pg; coll_ent_log2 = ent;
            dev_on = ~on;
        end else begin
            dev_base = base; dev_on = on; dev_two_lvl = two; dev_pg_log2 = pg; dev_ent_log2 = ent;
            coll_on = ~on;
        end
        inj_rd = erd; inj_wr = ewr;
        rd0 = n_rd; wr0 = n_wr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        poked = 0;
        if (!on) chk(done === 1'b1, "R1", "done one cycle after start", {63'h0, done}, 64'd1);
        while (!done && cyc < 100) begin
            if (poke && !poked && busy) begin
                // R11: a second request while busy must be ignored
                start = 1'b1; req_id = ~id; req_map = ~map; req_proc = ~pr; req_kind = ~kind;
                poked = 1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(done === 1'b1, "R11", "done reached", {63'h0, done}, 64'd1);
        chk(err === exp_err, etag, "err with done", {63'h0, err}, {63'h0, exp_err});
        chk((n_rd - rd0) == (exp_rd ? 1 : 0), exp_rd ? "R3" : "R2", "read count",
            64'(n_rd - rd0), exp_rd ? 64'd1 : 64'd0);
        if (exp_rd)
            chk(last_raddr === l1, "R3", "descriptor address", last_raddr, l1);
        chk((n_wr - wr0) == (exp_wr ? 1 : 0), poke ? "R11" : (exp_wr ? wtag : etag), "write count",
            64'(n_wr - wr0), exp_wr ? 64'd1 : 64'd0);
        if (exp_wr && (n_wr - wr0) == 1) begin
            chk(last_waddr === waddr, wtag, "entry address", last_waddr, waddr);
            chk(last_wdata === wdata, !map ? "R8" : (kind ? "R6" : "R7"), "entry data", last_wdata, wdata);
        end
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R11", "done single cycle", {62'h0, done, busy}, 64'd0);
        inj_rd = 0; inj_wr = 0;
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; start = 1'b0;
        req_kind = 0; req_id = '0; req_map = 0; req_size = '0; req_itt = '0; req_proc = '0;
        dev_base = '0; dev_on = 0; dev_two_lvl = 0; dev_pg_log2 = 5'd12; dev_ent_log2 = 4'd3;
        coll_base = '0; coll_on = 0; coll_two_lvl = 0; coll_pg_log2 = 5'd12; coll_ent_log2 = 4'd3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && err === 1'b0 && mem_req === 1'b0, "R11",
            "reset state", {60'h0, busy, done, err, mem_req}, 64'd0);

        // directed corners
        run_txn(1, 32'd5, 1, 5'd0, 44'd0, 16'h1234, 64'h1000_0000, 0, 0, 5'd12, 4'd3, 0, 0, 0); // R1
        run_txn(1, 32'd7, 1, 5'd0, 44'd0, 16'hBEEF, 64'h2000_0000, 1, 0, 5'd12, 4'd3, 0, 0, 0); // R2 R6
        run_txn(0, 32'd9, 1, 5'd17, 44'hABC_DEF0_1234, 16'h0, 64'h3000_0000, 1, 0, 5'd12, 4'd4, 0, 0, 0); // R7
        run_txn(0, 32'd9, 0, 5'd17, 44'hABC_DEF0_1234, 16'h0, 64'h3000_0000, 1, 0, 5'd12, 4'd4, 0, 0, 0); // R8
        run_txn(0, 32'd0, 1, 5'd3, 44'h1, 16'h0, 64'h4000_0000, 1, 1, 5'd12, 4'd3, 0, 0, 0); // R4 (desc bit63 clear)
        run_txn(1, 32'd1000, 1, 5'd0, 44'h0, 16'h77, 64'h5000_0000, 1, 1, 5'd12, 4'd3, 0, 0, 0); // R3 R5
        run_txn(1, 32'd1000, 1, 5'd0, 44'h0, 16'h77, 64'h5000_0000, 1, 1, 5'd12, 4'd3, 1, 0, 0); // R9
        run_txn(0, 32'd33, 1, 5'd2, 44'h55, 16'h0, 64'h6000_0000, 1, 0, 5'd13, 4'd3, 0, 1, 0); // R10
        run_txn(1, 32'd1000, 1, 5'd0, 44'h0, 16'h99, 64'h5000_0000, 1, 1, 5'd14, 4'd4, 0, 0, 1); // R11

        // constrained random
        for (int t = 0; t < 400; t++) begin
            logic [63:0] b;
            logic [31:0] id;
            b = {$urandom, $urandom} & 64'h000F_FFFF_FFFF_F000;
            id = ($urandom % 4 == 0) ? $urandom : ($urandom % 32'h0010_0000);
            run_txn(1'($urandom % 2), id, ($urandom % 6) != 0, 5'($urandom), {12'($urandom), 32'($urandom)},
                    16'($urandom), b, ($urandom % 8) != 0, 1'($urandom % 2),
                    5'(12 + $urandom % 5), 4'(3 + $urandom % 2),
                    ($urandom % 12) == 0, ($urandom % 12) == 0, ($urandom % 10) == 0);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule